// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. It picks a raw input, brings it into the timer clock domain through a two-stage synchronizer, and cleans it with a digital filter. It then detects the edge that software selected. A prescaler turns every N-th detected event into an effective capture. On each effective capture the running counter value, which arrives from outside the block, is stored in the capture register.

The event source can be the channel's own filtered input, the filtered signal of the paired neighbouring channel, or a one-cycle internal trigger pulse. When the block is built as the first channel of a timer, its raw input can instead be the XOR of three channel pins, which is useful for decoding Hall-sensor style inputs. A capture flag and an over-capture flag record what happened. The flag drives an interrupt request and a DMA request through separate enables. Software can set the flag without any input event, and it clears each flag with its own strobe.

Top module: `tmr_capture_chan`

## Requirements
- R1: A level change on the selected raw input produces a capture on the clock edge `2 + max(L,1)` edges after the edge that first samples it, where L is `cfg_filt_len`; L = 0 bypasses the filter, which gives the same latency as L = 1.
- R2: With L > 1, a change on the input that reverts before it has been sampled for L consecutive cycles produces no capture.
- R3: `cfg_xor_sel` = 1 (present only when `IS_FIRST` = 1) makes the raw input `ch_in ^ ch_in_n1 ^ ch_in_n2`. With `cfg_xor_sel` = 0 the raw input is `ch_in`, and the two other pins have no effect.
- R4: `cfg_pol` selects the edge: 2'b00 and 2'b10 select rising, 2'b01 selects falling, 2'b11 selects both.
- R5: `cfg_mode` selects the source: 0 = no capture; 1 = own filtered edge; 2 = edge of `peer_filt`, which captures on the edge where the new level is first sampled; 3 = `trig_pulse` high, which captures on that same edge. In modes 2 and 3 the channel pins have no effect.
- R6: `wr_ccr` loads `wr_data` into `ccr` on the next edge when `cfg_mode` = 0, and is ignored otherwise.
- R7: Only one of every N detected events is an effective capture, where N = 2^`cfg_psc` (1, 2, 4 or 8); the N-th event captures.
- R8: An effective capture loads `cnt_val` into `ccr` and sets `cap_flag`. It requires `cfg_cap_en` = 1. While `cfg_cap_en` = 0, events are ignored and the prescaler count returns to zero. After reset, `ccr`, both flags and both requests are 0.
- R9: A capture while `cap_flag` is already 1 sets `ovr_flag`.
- R10: `irq` = `cap_flag` AND `cfg_irq_en`; `dma_req` = `cap_flag` AND `cfg_dma_en`.
- R11: A one-cycle `sw_gen` pulse sets `cap_flag` without touching `ccr` or `ovr_flag`.
- R12: `clr_cap` clears `cap_flag` and `clr_ovr` clears `ovr_flag`, each independently; a setting event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_in | input | 1 | This channel's pin |
| ch_in_n1 | input | 1 | Second pin for the XOR input |
| ch_in_n2 | input | 1 | Third pin for the XOR input |
| peer_filt | input | 1 | Filtered signal of the paired channel |
| trig_pulse | input | 1 | Internal trigger, one-cycle pulse |
| cnt_val | input | CW | Running counter value |
| cfg_xor_sel | input | 1 | Use XOR of three pins as raw input |
| cfg_filt_len | input | FW | Filter length, 0 = bypass |
| cfg_pol | input | 2 | Edge polarity select |
| cfg_mode | input | 2 | Capture source select |
| cfg_psc | input | PSC_BITS | Prescaler exponent |
| cfg_cap_en | input | 1 | Capture enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_dma_en | input | 1 | DMA request enable |
| wr_ccr | input | 1 | Software write strobe for ccr |
| wr_data | input | CW | Software write data |
| sw_gen | input | 1 | Software event generation |
| clr_cap | input | 1 | Clear capture flag |
| clr_ovr | input | 1 | Clear over-capture flag |
| ccr | output | CW | Capture/compare register |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Over-capture flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The hardest state to reach is the prescaler sitting exactly one event short of a capture. The bench gets there by pulsing the capture enable to zero the count, selecting both edges, and toggling the pin N−1 times with enough spacing between toggles that each toggle clears the filter. It checks that the flag stays clear, then makes one more toggle and predicts the stored counter value from the sweep's own arithmetic. A second sweep over filter lengths 0 to 5 measures the exact capture cycle. A three-cycle glitch against a length-4 filter shows that a short pulse is rejected.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_OWN  = 2'd1,
      SRC_PEER = 2'd2,
      SRC_TRIG = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      POL_RISE = 2'b00,
      POL_FALL = 2'b01,
      POL_ALT  = 2'b10,
      POL_BOTH = 2'b11
   } pol_e;

   // edge hit for the chosen polarity, from current and previous level
   function automatic logic edge_hit(pol_e p, logic cur, logic prv);
      logic rise, fall;
      rise = cur & ~prv;
      fall = ~cur & prv;
      case (p)
         POL_FALL: edge_hit = fall;
         POL_BOTH: edge_hit = rise | fall;
         default:  edge_hit = rise;
      endcase
   endfunction
endpackage

// File: rtl/tcap_infilt.sv
module tcap_infilt #(
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          raw_i,
   input  logic [FW-1:0] len_i,
   output logic          filt_o
);
   generate
      if (FW < 1) begin : g_bad_fw
         $error("tcap_infilt: FW must be at least 1");
      end
   endgenerate

   logic          s1_q, s2_q;
   logic [FW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q   <= 1'b0;
         s2_q   <= 1'b0;
         filt_o <= 1'b0;
         run_q  <= '0;
      end else begin
         s1_q <= raw_i;
         s2_q <= s1_q;
         if (len_i == '0) begin
            filt_o <= s2_q;
            run_q  <= '0;
         end else if (s2_q == filt_o) begin
            run_q <= '0;
         end else if (run_q >= len_i - 1'b1) begin
            filt_o <= s2_q;
            run_q  <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   // any move of the filtered level must take the synchronized level
   assert_filt_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_o) |-> (filt_o == $past(s2_q)));
endmodule

// File: rtl/tcap_evsel.sv
module tcap_evsel
   import tcap_pkg::*;
#(
   parameter int PSC_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                own_f,
   input  logic                peer_f,
   input  logic                trig_p,
   input  logic [1:0]          mode_i,
   input  logic [1:0]          pol_i,
   input  logic [PSC_BITS-1:0] psc_i,
   input  logic                cap_en_i,
   output logic                eff_o
);
   localparam int PCW = (1 << PSC_BITS) - 1;

   generate
      if (PSC_BITS < 1 || PSC_BITS > 3) begin : g_bad_psc
         $error("tcap_evsel: PSC_BITS must be 1..3");
      end
   endgenerate

   src_e           src;
   pol_e           pol;
   logic           own_q, peer_q;
   logic           hit;
   logic [PCW-1:0] pc_q, lim;

   assign src = src_e'(mode_i);
   assign pol = pol_e'(pol_i);

   always_comb begin
      lim = '0;
      for (int i = 0; i < PCW; i++) begin
         if (i < int'(psc_i)) lim[i] = 1'b1;
      end
   end

   always_comb begin
      case (src)
         SRC_OWN:  hit = edge_hit(pol, own_f, own_q);
         SRC_PEER: hit = edge_hit(pol, peer_f, peer_q);
         SRC_TRIG: hit = trig_p;
         default:  hit = 1'b0;
      endcase
   end

   assign eff_o = cap_en_i && hit && (pc_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q  <= 1'b0;
         peer_q <= 1'b0;
         pc_q   <= '0;
      end else begin
         own_q  <= own_f;
         peer_q <= peer_f;
         if (!cap_en_i)    pc_q <= '0;
         else if (hit)     pc_q <= (pc_q >= lim) ? '0 : pc_q + 1'b1;
      end
   end

   // with N >= 2 two effective captures never come back to back
   assert_psc_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_o && psc_i != '0) |=> (!eff_o || psc_i != $past(psc_i)));
endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
   import tcap_pkg::*;
#(
   parameter int CW       = 16,
   parameter int FW       = 4,
   parameter int PSC_BITS = 2,
   parameter bit IS_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ch_in,
   input  logic                ch_in_n1,
   input  logic                ch_in_n2,
   input  logic                peer_filt,
   input  logic                trig_pulse,
   input  logic [CW-1:0]       cnt_val,
   input  logic                cfg_xor_sel,
   input  logic [FW-1:0]       cfg_filt_len,
   input  logic [1:0]          cfg_pol,
   input  logic [1:0]          cfg_mode,
   input  logic [PSC_BITS-1:0] cfg_psc,
   input  logic                cfg_cap_en,
   input  logic                cfg_irq_en,
   input  logic                cfg_dma_en,
   input  logic                wr_ccr,
   input  logic [CW-1:0]       wr_data,
   input  logic                sw_gen,
   input  logic                clr_cap,
   input  logic                clr_ovr,
   output logic [CW-1:0]       ccr,
   output logic                cap_flag,
   output logic                ovr_flag,
   output logic                irq,
   output logic                dma_req
);
   generate
      if (CW < 2) begin : g_bad_cw
         $error("tmr_capture_chan: CW must be at least 2");
      end
   endgenerate

   logic raw_in, own_filt, eff;

   generate
      if (IS_FIRST) begin : g_xor_in
         assign raw_in = cfg_xor_sel ? (ch_in ^ ch_in_n1 ^ ch_in_n2) : ch_in;
      end else begin : g_plain_in
         logic unused_pins;
         assign unused_pins = cfg_xor_sel ^ ch_in_n1 ^ ch_in_n2;
         assign raw_in      = ch_in;
      end
   endgenerate

   tcap_infilt #(.FW(FW)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_in),
      .len_i  (cfg_filt_len),
      .filt_o (own_filt)
   );

   tcap_evsel #(.PSC_BITS(PSC_BITS)) u_evsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .own_f    (own_filt),
      .peer_f   (peer_filt),
      .trig_p   (trig_pulse),
      .mode_i   (cfg_mode),
      .pol_i    (cfg_pol),
      .psc_i    (cfg_psc),
      .cap_en_i (cfg_cap_en),
      .eff_o    (eff)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ccr      <= '0;
         cap_flag <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         if (eff)                                ccr <= cnt_val;
         else if (wr_ccr && cfg_mode == SRC_OFF) ccr <= wr_data;

         if (eff || sw_gen)  cap_flag <= 1'b1;
         else if (clr_cap)   cap_flag <= 1'b0;

         if (eff && cap_flag) ovr_flag <= 1'b1;
         else if (clr_ovr)    ovr_flag <= 1'b0;
      end
   end

   assign irq     = cap_flag & cfg_irq_en;
   assign dma_req = cap_flag & cfg_dma_en;

   assert_no_cap_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == SRC_OFF) |-> !eff);

   assert_ccr_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != SRC_OFF && !eff) |=> $stable(ccr));

   assert_flag_on_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eff |=> cap_flag);

   assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> ($past(cap_flag) && $past(eff)));

   assert_swgen_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sw_gen |=> cap_flag);
endmodule

// File: tb/tmr_capture_chan_test.sv
`timescale 1ns/1ps
module tmr_capture_chan_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ch_in = 0, ch_in_n1 = 0, ch_in_n2 = 0, peer_filt = 0, trig_pulse = 0;
   logic [15:0] tc = '0;
   logic        cfg_xor_sel = 0;
   logic [3:0]  cfg_filt_len = '0;
   logic [1:0]  cfg_pol = 2'b00, cfg_mode = 2'd0, cfg_psc = 2'd0;
   logic        cfg_cap_en = 0, cfg_irq_en = 0, cfg_dma_en = 0;
   logic        wr_ccr = 0;
   logic [15:0] wr_data = '0;
   logic        sw_gen = 0, clr_cap = 0, clr_ovr = 0;
   logic [15:0] ccr;
   logic        cap_flag, ovr_flag, irq, dma_req;
   int          n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) tc <= tc + 16'd1;

   tmr_capture_chan uut (
      .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .ch_in_n1(ch_in_n1), .ch_in_n2(ch_in_n2),
      .peer_filt(peer_filt), .trig_pulse(trig_pulse), .cnt_val(tc),
      .cfg_xor_sel(cfg_xor_sel), .cfg_filt_len(cfg_filt_len), .cfg_pol(cfg_pol),
      .cfg_mode(cfg_mode), .cfg_psc(cfg_psc), .cfg_cap_en(cfg_cap_en),
      .cfg_irq_en(cfg_irq_en), .cfg_dma_en(cfg_dma_en), .wr_ccr(wr_ccr), .wr_data(wr_data),
      .sw_gen(sw_gen), .clr_cap(clr_cap), .clr_ovr(clr_ovr),
      .ccr(ccr), .cap_flag(cap_flag), .ovr_flag(ovr_flag), .irq(irq), .dma_req(dma_req));

   task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clr_flags();
      clr_cap = 1; clr_ovr = 1;
      wait_n(1);
      clr_cap = 0; clr_ovr = 0;
   endtask

   task automatic drive(input int which, input logic v);
      case (which)
         0: ch_in = v;
         1: ch_in_n1 = v;
         2: ch_in_n2 = v;
         default: cfg_xor_sel = v;
      endcase
   endtask

   // drive one signal, check no flag one edge early, then flag and stored value
   task automatic edge_cap(input int which, input logic v, input int d, input string r);
      logic [15:0] t0;
      clr_flags();
      t0 = tc;
      drive(which, v);
      wait_n(d);
      chk(r, "flag early", cap_flag, 0);
      wait_n(1);
      chk(r, "flag", cap_flag, 1);
      chk(r, "ccr", ccr, t0 + 16'(d));
   endtask

   task automatic no_cap(input int which, input logic v, input string r);
      clr_flags();
      drive(which, v);
      wait_n(10);
      chk(r, "no capture", cap_flag, 0);
   endtask

   task automatic prescale_reset();
      cfg_cap_en = 0;
      wait_n(1);
      cfg_cap_en = 1;
   endtask

   initial begin
      wait_n(3);
      rst_n = 1;
      wait_n(1);
      // R8 reset state
      chk("R8", "reset ccr", ccr, 0);
      chk("R8", "reset flag", cap_flag, 0);
      chk("R9", "reset ovr", ovr_flag, 0);
      chk("R10", "reset irq/dma", {irq, dma_req}, 0);

      cfg_mode = 2'd1; cfg_pol = 2'b11; cfg_cap_en = 1;
      // R1 filter length sweep, both edges
      for (int l = 0; l < 6; l++) begin
         cfg_filt_len = 4'(l);
         wait_n(2);
         edge_cap(0, ~ch_in, (l < 2) ? 3 : 2 + l, "R1");
         wait_n(4);
      end
      // R2 glitch shorter than filter length
      cfg_filt_len = 4'd4;
      clr_flags();
      ch_in = ~ch_in;
      wait_n(3);
      ch_in = ~ch_in;
      wait_n(12);
      chk("R2", "glitch rejected", cap_flag, 0);
      cfg_filt_len = 4'd0;

      // R4 polarity
      cfg_cap_en = 0; ch_in = 0; wait_n(8); cfg_cap_en = 1;
      cfg_pol = 2'b01;
      no_cap(0, 1'b1, "R4");
      edge_cap(0, 1'b0, 3, "R4");
      cfg_pol = 2'b00;
      edge_cap(0, 1'b1, 3, "R4");
      no_cap(0, 1'b0, "R4");
      cfg_pol = 2'b10;
      edge_cap(0, 1'b1, 3, "R4");
      no_cap(0, 1'b0, "R4");

      // R7 prescaler sweep
      cfg_pol = 2'b11;
      for (int p = 0; p < 4; p++) begin
         cfg_psc = 2'(p);
         prescale_reset();
         clr_flags();
         for (int i = 0; i < (1 << p) - 1; i++) begin
            ch_in = ~ch_in;
            wait_n(6);
         end
         chk("R7", "before Nth event", cap_flag, 0);
         edge_cap(0, ~ch_in, 3, "R7");
      end
      cfg_psc = 2'd0;
      prescale_reset();

      // R8 capture enable off
      begin
         logic [15:0] keep;
         keep = ccr;
         cfg_cap_en = 0;
         no_cap(0, ~ch_in, "R8");
         chk("R8", "ccr held", ccr, {16'd0, keep});
         cfg_cap_en = 1;
      end

      // R9 over-capture, R12 independent clears
      clr_flags();
      ch_in = ~ch_in; wait_n(6);
      chk("R9", "first capture ovr", {cap_flag, ovr_flag}, 2'b10);
      ch_in = ~ch_in; wait_n(6);
      chk("R9", "second capture ovr", {cap_flag, ovr_flag}, 2'b11);
      clr_cap = 1; wait_n(1); clr_cap = 0;
      chk("R12", "clr cap only", {cap_flag, ovr_flag}, 2'b01);
      clr_ovr = 1; wait_n(1); clr_ovr = 0;
      chk("R12", "clr ovr", {cap_flag, ovr_flag}, 2'b00);

      // R10 request gating
      ch_in = ~ch_in; wait_n(6);
      cfg_irq_en = 1; cfg_dma_en = 0; wait_n(1);
      chk("R10", "irq only", {irq, dma_req}, 2'b10);
      cfg_irq_en = 0; cfg_dma_en = 1; wait_n(1);
      chk("R10", "dma only", {irq, dma_req}, 2'b01);
      cfg_irq_en = 1;
      clr_flags();
      chk("R10", "flag low", {irq, dma_req}, 2'b00);

      // R11 software generate
      begin
         logic [15:0] keep;
         keep = ccr;
         sw_gen = 1; wait_n(1); sw_gen = 0;
         chk("R11", "flag/ovr", {cap_flag, ovr_flag}, 2'b10);
         chk("R11", "ccr kept", ccr, {16'd0, keep});
         chk("R11", "irq from swgen", irq, 1);
      end
      cfg_irq_en = 0; cfg_dma_en = 0;

      // R5 trigger source
      cfg_mode = 2'd3;
      no_cap(0, ~ch_in, "R5");
      begin
         logic [15:0] t0;
         clr_flags();
         t0 = tc;
         trig_pulse = 1; wait_n(1); trig_pulse = 0;
         chk("R5", "trig ccr", ccr, {16'd0, t0});
         chk("R5", "trig flag", cap_flag, 1);
      end
      // R5 peer source, rising edges
      cfg_mode = 2'd2; cfg_pol = 2'b00;
      no_cap(0, ~ch_in, "R5");
      begin
         logic [15:0] t0;
         clr_flags();
         t0 = tc;
         peer_filt = 1; wait_n(1);
         chk("R5", "peer ccr", ccr, {16'd0, t0});
         chk("R5", "peer flag", cap_flag, 1);
      end
      // R5 / R6 mode off: no capture, write accepted
      cfg_mode = 2'd0; cfg_pol = 2'b11;
      no_cap(0, ~ch_in, "R5");
      wr_ccr = 1; wr_data = 16'hA5C3; wait_n(1); wr_ccr = 0;
      chk("R6", "write in mode 0", ccr, 16'hA5C3);
      cfg_mode = 2'd1; wait_n(2);
      wr_ccr = 1; wr_data = 16'h1234; wait_n(1); wr_ccr = 0;
      chk("R6", "write ignored in input mode", ccr, 16'hA5C3);

      // R3 XOR input
      cfg_cap_en = 0; ch_in = 0; ch_in_n1 = 0; ch_in_n2 = 0; cfg_xor_sel = 0;
      wait_n(8); cfg_cap_en = 1;
      no_cap(1, 1'b1, "R3");
      edge_cap(3, 1'b1, 3, "R3");
      edge_cap(2, 1'b1, 3, "R3");
      edge_cap(0, 1'b1, 3, "R3");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule